// File: doc/BRIEF.md
# Edge-Selective Status Interrupt Enables

This block watches four live link status levels: host disconnect, bus-voltage valid, session valid and session end. It raises an interrupt when one of them changes in a direction that software has enabled. Two small enable registers decide which directions count. One register covers 0-to-1 changes and the other covers 1-to-0 changes, and each status source has its own bit in both. Each register can be reached at three addresses: one loads the value, one ORs bits in, and one clears bits. Software can therefore change a single enable without a read-modify-write.

When an enabled change is seen, a per-source pending flag latches and the interrupt output goes high. At the same time, a one-cycle event strobe carries the synchronised status vector to a status-report path. Software clears pending flags by pulsing an acknowledge together with a bit mask.

Top module: `link_irq_enable_bank`

## Requirements
- R1: After reset, both enable registers hold 0x0F, so every direction of every source is enabled. The irq and evt_valid outputs are 0 after reset.
- R2: Status and enable bit positions are: bit 0 host disconnect, bit 1 bus-voltage valid, bit 2 session valid, bit 3 session end. A write to 0x0D loads the rising-edge enable register from wr_data[3:0]. A write to 0x10 loads the falling-edge enable register in the same way.
- R3: A write to 0x0E ORs wr_data[3:0] into the rising-edge enables. A write to 0x11 does the same for the falling-edge enables.
- R4: A write to 0x0F clears the rising-edge enable bits that are 1 in wr_data[3:0]. A write to 0x12 does the same for the falling-edge enables.
- R5: rd_data is combinational from addr. Any of 0x0D..0x0F returns the rising-edge enables, and any of 0x10..0x12 returns the falling-edge enables. Bits 7:4 read 0 and ignore writes. Any other address reads 0, and writes to other addresses change neither register.
- R6: Each status input passes through two synchroniser flops before edge detection. evt_valid rises after the third rising clock edge at which the new input level is present.
- R7: A 0-to-1 change on a source produces an event and a pending flag only while that source's rising-edge enable bit is 1.
- R8: A 1-to-0 change on a source produces an event and a pending flag only while that source's falling-edge enable bit is 1.
- R9: Each input change that is enabled gives exactly one evt_valid pulse of one cycle, with evt_status equal to the synchronised status after the change. Changes on several sources in the same cycle share one pulse.
- R10: irq is the OR of the per-source pending flags. A cycle with ack_valid high clears the flags selected by ack_mask, and leaves the other flags pending.
- R11: If a source's enabled edge and an acknowledge of that source fall in the same cycle, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 8 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| status_in | input | 4 | Asynchronous status levels (bit map as in R2) |
| ack_valid | input | 1 | Pending-flag acknowledge strobe |
| ack_mask | input | 4 | Sources cleared by the acknowledge |
| irq | output | 1 | Interrupt, OR of the pending flags |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_status | output | 4 | Synchronised status carried with the event |

## Verification
The pending logic can set and clear the same source flag in one cycle. This happens when software acknowledges a source in exactly the cycle where the edge detector reports a new enabled change on it. The bench provokes this by changing a status input and asserting ack_valid with that source's bit two falling clock edges later, which lands the acknowledge in the detection cycle. The result passes if the event still reaches the scoreboard and irq stays high afterwards, and fails if the flag has cleared.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wr_op_e;

  typedef enum int {
    SRC_HOST_DISC  = 0,
    SRC_VBUS_VALID = 1,
    SRC_SESS_VALID = 2,
    SRC_SESS_END   = 3
  } src_idx_e;

  localparam int NUM_ALIAS = 3;

endpackage

// File: rtl/lirq_en_reg.sv
module lirq_en_reg
  import lirq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NSRC = 4,
  parameter logic [AW-1:0] BASE = 8'h0D,
  parameter logic [NSRC-1:0] RST_VAL = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NSRC-1:0] en_q,
  output logic            hit_range
);

  localparam logic [AW-1:0] A_LOAD = BASE;
  localparam logic [AW-1:0] A_SET  = BASE + AW'(1);
  localparam logic [AW-1:0] A_CLR  = BASE + AW'(NUM_ALIAS - 1);

  wr_op_e          op;
  logic [NSRC-1:0] wbits;

  assign wbits = wr_data[NSRC-1:0];

  always_comb begin
    if (addr == A_LOAD)      op = OP_LOAD;
    else if (addr == A_SET)  op = OP_SET;
    else if (addr == A_CLR)  op = OP_CLR;
    else                     op = OP_NONE;
  end

  assign hit_range = (op != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= RST_VAL;
    end else if (wr_en) begin
      case (op)
        OP_LOAD: en_q <= wbits;
        OP_SET:  en_q <= en_q | wbits;
        OP_CLR:  en_q <= en_q & ~wbits;
        default: en_q <= en_q;
      endcase
    end
  end

endmodule

// File: rtl/lirq_sync_edge.sv
module lirq_sync_edge #(
  parameter int NSRC = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_in,
  output logic [NSRC-1:0] cur,
  output logic [NSRC-1:0] rise,
  output logic [NSRC-1:0] fall
);

  logic [NSRC-1:0] chain [STAGES];
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= status_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign cur  = chain[STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

endmodule

// File: rtl/lirq_pending.sv
module lirq_pending #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] cur,
  input  logic            ack_valid,
  input  logic [NSRC-1:0] ack_mask,
  output logic [NSRC-1:0] pend_q,
  output logic            evt_valid,
  output logic [NSRC-1:0] evt_status
);

  logic [NSRC-1:0] clr_mask;

  assign clr_mask = ack_valid ? ack_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      evt_valid  <= 1'b0;
      evt_status <= '0;
    end else begin
      pend_q    <= (pend_q & ~clr_mask) | hit;
      evt_valid <= |hit;
      if (|hit) evt_status <= cur;
    end
  end

endmodule

// File: rtl/link_irq_enable_bank.sv
module link_irq_enable_bank #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NSRC = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] RISE_BASE = 8'h0D,
  parameter logic [AW-1:0] FALL_BASE = 8'h10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic [NSRC-1:0] status_in,
  input  logic            ack_valid,
  input  logic [NSRC-1:0] ack_mask,
  output logic            irq,
  output logic            evt_valid,
  output logic [NSRC-1:0] evt_status
);

  localparam int NREG = 2;
  localparam logic [AW-1:0] BASES [NREG] = '{RISE_BASE, FALL_BASE};

  logic [NSRC-1:0] en_vec  [NREG];
  logic            sel_vec [NREG];
  logic [NSRC-1:0] rise_en, fall_en;
  logic [NSRC-1:0] cur, rise, fall, edge_hit, pend_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    lirq_en_reg #(
      .AW(AW), .DW(DW), .NSRC(NSRC), .BASE(BASES[g]), .RST_VAL('1)
    ) i_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .en_q(en_vec[g]), .hit_range(sel_vec[g])
    );
  end

  assign rise_en = en_vec[0];
  assign fall_en = en_vec[1];

  always_comb begin
    rd_data = '0;
    if (sel_vec[0])      rd_data = DW'(rise_en);
    else if (sel_vec[1]) rd_data = DW'(fall_en);
  end

  lirq_sync_edge #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .status_in(status_in),
    .cur(cur), .rise(rise), .fall(fall)
  );

  assign edge_hit = (rise & rise_en) | (fall & fall_en);

  lirq_pending #(.NSRC(NSRC)) i_pend (
    .clk(clk), .rst(rst), .hit(edge_hit), .cur(cur),
    .ack_valid(ack_valid), .ack_mask(ack_mask),
    .pend_q(pend_q), .evt_valid(evt_valid), .evt_status(evt_status)
  );

  assign irq = |pend_q;

endmodule

// File: rtl/link_irq_enable_chk.sv
module link_irq_enable_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NSRC = 4,
  parameter logic [AW-1:0] RISE_BASE = 8'h0D,
  parameter logic [AW-1:0] FALL_BASE = 8'h10
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic            ack_valid,
  input logic [NSRC-1:0] ack_mask,
  input logic            irq,
  input logic            evt_valid,
  input logic [NSRC-1:0] rise_q,
  input logic [NSRC-1:0] fall_q,
  input logic [NSRC-1:0] hit,
  input logic [NSRC-1:0] pend
);

  logic rise_range, fall_range;
  assign rise_range = (addr >= RISE_BASE) && (addr <= RISE_BASE + AW'(2));
  assign fall_range = (addr >= FALL_BASE) && (addr <= FALL_BASE + AW'(2));

  AST_RISE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RISE_BASE) |=> (rise_q == $past(wr_data[NSRC-1:0]))); // R2
  AST_FALL_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == FALL_BASE + AW'(1)) |=> (fall_q == ($past(fall_q) | $past(wr_data[NSRC-1:0])))); // R3
  AST_RISE_CLR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RISE_BASE + AW'(2)) |=> (rise_q == ($past(rise_q) & ~$past(wr_data[NSRC-1:0])))); // R4
  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rise_range) |=> $stable(rise_q)); // R5
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && fall_range) |=> $stable(fall_q)); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:NSRC] == '0); // R5
  AST_EVT_IRQ: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> irq); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> ((pend & $past(ack_mask & ~hit)) == '0)); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((pend & $past(hit)) == $past(hit))); // R11

endmodule

bind link_irq_enable_bank link_irq_enable_chk #(
  .AW(AW), .DW(DW), .NSRC(NSRC), .RISE_BASE(RISE_BASE), .FALL_BASE(FALL_BASE)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .ack_valid(ack_valid), .ack_mask(ack_mask), .irq(irq),
  .evt_valid(evt_valid), .rise_q(rise_en), .fall_q(fall_en),
  .hit(edge_hit), .pend(pend_q)
);

// File: tb/test_link_irq_enable_bank.sv
module test_link_irq_enable_bank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] status_in = 4'h0;
  logic       ack_valid = 1'b0;
  logic [3:0] ack_mask = 4'h0;
  logic       irq, evt_valid;
  logic [3:0] evt_status;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [3:0] exp_q [$];
  logic [3:0] rise_m = 4'hF;
  logic [3:0] fall_m = 4'hF;

  always #5 clk = ~clk;

  link_irq_enable_bank i_link_irq_enable_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .status_in(status_in), .ack_valid(ack_valid),
    .ack_mask(ack_mask), .irq(irq), .evt_valid(evt_valid), .evt_status(evt_status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && evt_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7/R8/R9: actual unexpected event 0x%0h expected none", evt_status);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check("R9 event status", {4'h0, evt_status}, {4'h0, e});
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    case (a)
      8'h0D: rise_m = d[3:0];
      8'h0E: rise_m = rise_m | d[3:0];
      8'h0F: rise_m = rise_m & ~d[3:0];
      8'h10: fall_m = d[3:0];
      8'h11: fall_m = fall_m | d[3:0];
      8'h12: fall_m = fall_m & ~d[3:0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // driver side of the scoreboard: pushes an item when the model says an event is due
  task automatic push_status(input logic [3:0] nv);
    logic [3:0] old;
    old = status_in;
    if (|((nv & ~old & rise_m) | (~nv & old & fall_m))) exp_q.push_back(nv);
    @(negedge clk);
    status_in = nv;
  endtask

  task automatic apply_status(input logic [3:0] nv);
    push_status(nv);
    repeat (5) @(negedge clk);
  endtask

  task automatic do_ack(input logic [3:0] m);
    @(negedge clk);
    ack_valid = 1'b1; ack_mask = m;
    @(negedge clk);
    ack_valid = 1'b0; ack_mask = 4'h0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 irq after reset", {7'h0, irq}, 8'h00);
    check("R1 evt_valid after reset", {7'h0, evt_valid}, 8'h00);
    reg_read_check("R1 rise reset 0x0D", 8'h0D, 8'h0F);
    reg_read_check("R1 rise reset 0x0F", 8'h0F, 8'h0F);
    reg_read_check("R1 fall reset 0x10", 8'h10, 8'h0F);
    reg_read_check("R5 fall alias 0x12", 8'h12, 8'h0F);
    reg_read_check("R5 below range", 8'h0C, 8'h00);
    reg_read_check("R5 above range", 8'h13, 8'h00);

    reg_write(8'h0D, 8'hF5);
    reg_read_check("R2 rise load, R5 reserved ignored", 8'h0E, 8'h05);
    reg_write(8'h10, 8'h0A);
    reg_read_check("R2 fall load", 8'h11, 8'h0A);
    reg_write(8'h0E, 8'h02);
    reg_read_check("R3 rise set", 8'h0D, 8'h07);
    reg_write(8'h0F, 8'h01);
    reg_read_check("R4 rise clear", 8'h0F, 8'h06);
    reg_write(8'h11, 8'h01);
    reg_read_check("R3 fall set", 8'h10, 8'h0B);
    reg_write(8'h12, 8'h08);
    reg_read_check("R4 fall clear", 8'h12, 8'h03);
    reg_write(8'h13, 8'hFF);
    reg_read_check("R5 outside write rise", 8'h0D, 8'h06);
    reg_read_check("R5 outside write fall", 8'h10, 8'h03);

    // rise enables bits 1,2; fall enables bits 0,1
    push_status(4'h4);
    @(negedge clk); @(negedge clk);
    check("R6 no event before third edge", {7'h0, evt_valid}, 8'h00);
    @(negedge clk);
    check("R6 event after third edge", {7'h0, evt_valid}, 8'h01);
    @(negedge clk);
    check("R9 one-cycle pulse", {7'h0, evt_valid}, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 enabled rise pends", {7'h0, irq}, 8'h01);
    apply_status(4'h5);                 // R7 disabled rise on host disconnect
    apply_status(4'hD);                 // R7 disabled rise on session end
    apply_status(4'hC);                 // R8 enabled fall on host disconnect
    apply_status(4'h8);                 // R8 disabled fall on session valid
    do_ack(4'h4);
    check("R10 partial ack keeps irq", {7'h0, irq}, 8'h01);
    do_ack(4'h1);
    check("R10 full ack drops irq", {7'h0, irq}, 8'h00);

    // R11: ack lands in the detection cycle of an enabled rise on bit 1
    push_status(4'hA);
    @(negedge clk); @(negedge clk);
    ack_valid = 1'b1; ack_mask = 4'h2;
    @(negedge clk);
    ack_valid = 1'b0; ack_mask = 4'h0;
    #1;
    check("R11 set wins over ack", {7'h0, irq}, 8'h01);
    repeat (2) @(negedge clk);
    do_ack(4'h2);
    check("R10 ack after set", {7'h0, irq}, 8'h00);

    // simultaneous changes on all sources share one event
    reg_write(8'h0D, 8'h0F);
    reg_write(8'h10, 8'h0F);
    apply_status(4'h5);
    check("R9 multi-source pends", {7'h0, irq}, 8'h01);
    do_ack(4'hF);
    check("R10 ack all", {7'h0, irq}, 8'h00);
    reg_write(8'h0F, 8'h0F);
    reg_write(8'h12, 8'h0F);
    apply_status(4'hA);
    check("R7 R8 all disabled no irq", {7'h0, irq}, 8'h00);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule